// File: doc/BRIEF.md
# Slave Serial Audio Transmitter

This block sends a stereo pair of 16-bit two's complement samples on one serial data line. An external master drives both the bit clock and the word clock, so the block only listens to them. It runs entirely in a faster system clock domain. Both incoming clocks are synchronised there, their edges are detected, and the data line is updated after each detected bit-clock falling edge. A receiver that samples on bit-clock rising edges then sees a stable bit.

A static format input selects one of two framings. In left-justified framing the left slot is the word-clock-high half and the MSB follows the word clock edge at once. In I2S framing the left slot is the word-clock-low half and the MSB comes one bit period later. Both parallel samples are copied into a holding register when a left slot starts, so an update in the middle of a frame never mixes halves of two samples. A force-zero request replaces the words with the bipolar-zero code. It acts word by word, so the slot timing never breaks.

Top module: `audio_tx_slave`

## Requirements
- R1: Each slot carries one 16-bit two's complement word, most significant bit first and least significant bit last, one bit per bit period.
- R2: With `fmt_i2s` = 0, the word-clock-high slot is left. Let rise r be the first bit-clock rising edge that samples the new word-clock level. The MSB is presented for capture at rise r+1 and bit 0 at rise r+16.
- R3: With `fmt_i2s` = 1, the word-clock-low slot is left and the MSB is presented for capture at rise r+2 and bit 0 at rise r+17.
- R4: Every bit period after the 16 data bits of a word, up to the next word's MSB, carries 0.
- R5: `sdata_out` changes only in the system cycle after a detected bit-clock falling edge. It is stable from a bit-clock rising edge through the following high phase.
- R6: Both `left_in` and `right_in` are captured at rise r of a left slot. Later changes to them have no effect on the words sent in that frame.
- R7: If `force_zero` is high when a word is loaded (at the falling edge after rise r in R2 framing, after rise r+1 in R3 framing), all 16 bits of that word are 0. Slot timing and the next word are unaffected.
- R8: While `rst_n` is low, `sdata_out` is 0 and the holding register is cleared. After reset, `sdata_out` stays 0 until the first word-clock level change has been sampled.
- R9: Framing holds for frames of 32 and 64 bit clocks (slots of 16 and 32 bit periods). With 16-bit slots, bit 0 of a word overlaps the start of the next slot as given by R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Bit clock from the external master |
| wclk_in | input | 1 | Word clock from the external master |
| fmt_i2s | input | 1 | Framing select: 0 left-justified, 1 I2S (static) |
| force_zero | input | 1 | Replace loaded words with bipolar zero |
| left_in | input | 16 | Left-channel sample, two's complement |
| right_in | input | 16 | Right-channel sample, two's complement |
| sdata_out | output | 1 | Serial audio data |

## Verification
The assertions assume that each bit-clock phase lasts several system clocks, longer than the synchroniser depth plus one, so that every edge is seen and no rise and fall fall into one cycle. They also assume that the word clock moves only together with bit-clock falling edges, and that `force_zero`, `left_in` and `right_in` are synchronous to the system clock. The bench acts as the master with 8 system clocks per bit-clock phase, changing the word clock with each falling edge. It updates the samples and the force-zero request six system clocks into the high phase, after the rise has been detected and before the next fall can be. The format changes only while reset is held.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  typedef enum logic {
    FMT_LEFT_JUST = 1'b0,
    FMT_I2S       = 1'b1
  } frame_fmt_e;

  localparam int unsigned SYNC_DEPTH = 2;

  // Word clock level that marks the left slot for a given framing.
  function automatic logic is_left_slot(frame_fmt_e fmt, logic wclk_lvl);
    return (fmt == FMT_I2S) ? ~wclk_lvl : wclk_lvl;
  endfunction

endpackage

// File: rtl/aud_sync.sv
module aud_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], async_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign sync_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/aud_slot_tracker.sv
module aud_slot_tracker
  import aud_tx_pkg::*;
#(
  parameter int unsigned POS_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk_s,
  input  logic       wclk_s,
  input  frame_fmt_e fmt,
  output logic       rise_o,
  output logic       fall_o,
  output logic       cap_left_o,
  output logic       load_o,
  output logic       load_left_o,
  output logic       synced_o
);

  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             bclk_q, bclk_d;
  logic             wsmp_q, wsmp_d;
  logic             ref_q, ref_d;
  logic             synced_q, synced_d;
  logic [POS_W-1:0] pos_q, pos_d;

  logic             rise, fall, slot_edge;
  logic [POS_W-1:0] load_pos;

  always_comb begin
    rise      = bclk_s & ~bclk_q;
    fall      = ~bclk_s & bclk_q;
    slot_edge = rise & ref_q & (wclk_s != wsmp_q);
    load_pos  = (fmt == FMT_I2S) ? POS_W'(1) : '0;
  end

  // Next-state: word clock sampled on each bit clock rise.
  always_comb begin
    bclk_d   = bclk_s;
    wsmp_d   = wsmp_q;
    ref_d    = ref_q;
    synced_d = synced_q;
    pos_d    = pos_q;
    if (rise) begin
      wsmp_d = wclk_s;
      ref_d  = 1'b1;
      if (slot_edge) begin
        pos_d    = '0;
        synced_d = 1'b1;
      end else if (pos_q != POS_MAX) begin
        pos_d = pos_q + POS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q   <= 1'b0;
      wsmp_q   <= 1'b0;
      ref_q    <= 1'b0;
      synced_q <= 1'b0;
      pos_q    <= '0;
    end else begin
      bclk_q   <= bclk_d;
      wsmp_q   <= wsmp_d;
      ref_q    <= ref_d;
      synced_q <= synced_d;
      pos_q    <= pos_d;
    end
  end

  assign rise_o      = rise;
  assign fall_o      = fall;
  assign cap_left_o  = slot_edge & is_left_slot(fmt, wclk_s);
  assign load_o      = fall & synced_q & (pos_q == load_pos);
  assign load_left_o = is_left_slot(fmt, wsmp_q);
  assign synced_o    = synced_q;

endmodule

// File: rtl/aud_word_shifter.sv
module aud_word_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic              load_en,
  input  logic              load_left,
  input  logic              zero_req,
  input  logic              shift_en,
  output logic [WORD_W-1:0] hold_l_o,
  output logic [WORD_W-1:0] hold_r_o,
  output logic              sdata_o
);

  logic [WORD_W-1:0] hold_l_q, hold_l_d;
  logic [WORD_W-1:0] hold_r_q, hold_r_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [WORD_W-1:0] load_word;

  always_comb begin
    load_word = zero_req ? '0 : (load_left ? hold_l_q : hold_r_q);
  end

  always_comb begin
    hold_l_d = hold_l_q;
    hold_r_d = hold_r_q;
    shreg_d  = shreg_q;
    if (cap_en) begin
      hold_l_d = left_i;
      hold_r_d = right_i;
    end
    if (load_en) begin
      shreg_d = load_word;
    end else if (shift_en) begin
      shreg_d = {shreg_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      shreg_q  <= '0;
    end else begin
      hold_l_q <= hold_l_d;
      hold_r_q <= hold_r_d;
      shreg_q  <= shreg_d;
    end
  end

  assign hold_l_o = hold_l_q;
  assign hold_r_o = hold_r_q;
  assign sdata_o  = shreg_q[WORD_W-1];

endmodule

// File: rtl/audio_tx_slave.sv
module audio_tx_slave
  import aud_tx_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned STAGES = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_in,
  input  logic              wclk_in,
  input  logic              fmt_i2s,
  input  logic              force_zero,
  input  logic [WORD_W-1:0] left_in,
  input  logic [WORD_W-1:0] right_in,
  output logic              sdata_out
);

  localparam int unsigned N_CLKS = 2;

  frame_fmt_e        fmt;
  logic [N_CLKS-1:0] clk_raw, clk_sync;
  logic              rise_evt, fall_evt, cap_evt, load_evt, load_left, synced;
  logic [WORD_W-1:0] hold_l, hold_r;

  assign fmt     = frame_fmt_e'(fmt_i2s);
  assign clk_raw = {wclk_in, bclk_in};

  aud_sync #(
    .WIDTH  (N_CLKS),
    .STAGES (STAGES)
  ) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (clk_raw),
    .sync_o  (clk_sync)
  );

  aud_slot_tracker #(
    .POS_W (2)
  ) track_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_s      (clk_sync[0]),
    .wclk_s      (clk_sync[1]),
    .fmt         (fmt),
    .rise_o      (rise_evt),
    .fall_o      (fall_evt),
    .cap_left_o  (cap_evt),
    .load_o      (load_evt),
    .load_left_o (load_left),
    .synced_o    (synced)
  );

  aud_word_shifter #(
    .WORD_W (WORD_W)
  ) shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_evt),
    .left_i    (left_in),
    .right_i   (right_in),
    .load_en   (load_evt),
    .load_left (load_left),
    .zero_req  (force_zero),
    .shift_en  (fall_evt),
    .hold_l_o  (hold_l),
    .hold_r_o  (hold_r),
    .sdata_o   (sdata_out)
  );

endmodule

// File: rtl/audio_tx_slave_chk.sv
module audio_tx_slave_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sdata_out,
  input logic              force_zero,
  input logic              rise_evt,
  input logic              fall_evt,
  input logic              cap_evt,
  input logic              load_evt,
  input logic              load_left,
  input logic              synced,
  input logic [WORD_W-1:0] hold_l,
  input logic [WORD_W-1:0] hold_r
);

  assert_idle_in_reset_R8: assert property (@(posedge clk)
    !rst_n |-> !sdata_out);

  assert_zero_before_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> !sdata_out);

  assert_change_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_out) |-> $past(fall_evt));

  assert_capture_only_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> rise_evt);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> ($stable(hold_l) && $stable(hold_r)));

  assert_forced_word_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && force_zero) |=> !sdata_out);

  assert_left_msb_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !force_zero && load_left) |=> (sdata_out == $past(hold_l[WORD_W-1])));

  assert_right_msb_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !force_zero && !load_left) |=> (sdata_out == $past(hold_r[WORD_W-1])));

endmodule

bind audio_tx_slave audio_tx_slave_chk #(.WORD_W(WORD_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sdata_out  (sdata_out),
  .force_zero (force_zero),
  .rise_evt   (rise_evt),
  .fall_evt   (fall_evt),
  .cap_evt    (cap_evt),
  .load_evt   (load_evt),
  .load_left  (load_left),
  .synced     (synced),
  .hold_l     (hold_l),
  .hold_r     (hold_r)
);

// File: tb/audio_tx_slave_tb_top.sv
module audio_tx_slave_tb_top;

  logic        clk;
  logic        rst_n;
  logic        bclk, wclk, fmt_i2s, force_zero;
  logic [15:0] left_in, right_in;
  logic        sdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench model of the serial stream
  bit          have_ref, synced, slot_left, cur_fz, prev_fz;
  logic        cur_lvl;
  logic [15:0] held_l, held_r, cur_word, prev_word;
  int          kpos, cur_len, prev_len, cur_half;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  audio_tx_slave dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_in    (bclk),
    .wclk_in    (wclk),
    .fmt_i2s    (fmt_i2s),
    .force_zero (force_zero),
    .left_in    (left_in),
    .right_in   (right_in),
    .sdata_out  (sdata)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: sdata_out got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [15:0] pick_sample();
    case ($urandom_range(0, 7))
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic do_bit(input logic lvl);
    logic  got, exp;
    int    d, idx;
    string tag, base;
    bclk = 1'b0;
    wclk = lvl;
    repeat (8) @(negedge clk);
    got  = sdata;
    d    = fmt_i2s ? 2 : 1;
    base = fmt_i2s ? "R3/R1/R6" : "R2/R1/R6";
    if (have_ref && lvl != cur_lvl) begin
      prev_word = cur_word;
      prev_fz   = cur_fz;
      prev_len  = cur_len;
      cur_len   = 1;
      kpos      = 0;
      synced    = 1;
      slot_left = fmt_i2s ? !lvl : lvl;
      if (slot_left) begin
        held_l = left_in;
        held_r = right_in;
      end
      cur_word = '0;
      cur_fz   = 0;
    end else begin
      kpos++;
      cur_len++;
    end
    have_ref = 1;
    cur_lvl  = lvl;
    if (!synced) begin
      exp = 1'b0;
      tag = "R8";
    end else if (kpos >= d) begin
      idx = kpos - d;
      exp = (idx < 16) ? cur_word[15-idx] : 1'b0;
      tag = cur_fz ? "R7" : ((idx < 16) ? base : "R4");
    end else begin
      idx = kpos + prev_len - d;
      exp = (idx >= 0 && idx < 16) ? prev_word[15-idx] : 1'b0;
      tag = prev_fz ? "R7" : ((idx >= 0 && idx < 16) ? base : "R4");
    end
    if (cur_half == 32) tag = {tag, "/R9"};
    check(got, exp, tag);
    bclk = 1'b1;
    repeat (6) @(negedge clk);
    check(sdata, got, "R5");
    left_in  = pick_sample();
    right_in = pick_sample();
    if ($urandom_range(0, 19) == 0) force_zero = ~force_zero;
    if (synced && kpos == d - 1) begin
      cur_fz   = force_zero;
      cur_word = force_zero ? 16'h0000 : (slot_left ? held_l : held_r);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset(input logic f);
    rst_n      = 1'b0;
    fmt_i2s    = f;
    force_zero = 1'b0;
    bclk       = 1'b0;
    wclk       = f;
    left_in    = pick_sample();
    right_in   = pick_sample();
    repeat (5) @(negedge clk);
    check(sdata, 1'b0, "R8");
    have_ref = 0; synced = 0; slot_left = 0; cur_fz = 0; prev_fz = 0;
    cur_lvl = f; held_l = '0; held_r = '0; cur_word = '0; prev_word = '0;
    kpos = 0; cur_len = 0; prev_len = 0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input logic f, input int half, input int frames);
    cur_half = half;
    do_reset(f);
    repeat (4) do_bit(f);   // no word clock change yet: stays zero (R8)
    for (int fr = 0; fr < frames; fr++) begin
      for (int i = 0; i < half; i++) do_bit(!f);
      for (int i = 0; i < half; i++) do_bit(f);
    end
    repeat (3) do_bit(!f);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    bclk = 1'b0; wclk = 1'b0; fmt_i2s = 1'b0; force_zero = 1'b0;
    left_in = '0; right_in = '0;
    repeat (3) @(negedge clk);
    run(1'b0, 16, 8);
    run(1'b0, 32, 6);
    run(1'b1, 16, 8);
    run(1'b1, 32, 6);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule